// File: doc/BRIEF.md
# Exception Escalation and Shutdown Controller

This block sits on the processor side of an exception path and drives the delivery of one exception at a time. A request carries a vector number, an optional error code and, for page faults, the faulting linear address. The controller locates the gate for the vector in a descriptor table given by a base address and a byte limit. It asks an external fetch port whether that gate is present, then opens a one-cycle frame-save window in which the stack logic can report a failure. If all of this succeeds, the handler vector and the error code are issued.

A failure at any stage of delivery is itself a fault. A failure during a first-level delivery is converted into a double fault, which uses vector 8 and an error code of zero. A failure while the double fault is being delivered never vectors anywhere. Instead the controller enters shutdown: it emits one shutdown bus-cycle strobe and halts. Only a non-maskable interrupt or a reset leaves shutdown. A reset restarts instruction fetch at a fixed address.

Top module: `exc_escalate_ctrl`

## Requirements
- R1: When the gate fetch is acknowledged at once and no stage fails, `hnd_valid` is high for exactly one cycle. That cycle follows the fourth rising edge, counting the edge that samples `exc_req`. In that cycle `hnd_vec` equals the requested vector, and `hnd_err`/`hnd_err_vld` carry the request's error code and its valid flag.
- R2: The gate for vector v is at address `idt_base + 8*v`. This address is driven on `desc_addr` while `desc_req` is high. The gate exists only if `8*v + 7 <= idt_limit`.
- R3: A gate beyond the limit, a gate reported not present, or `push_fault` high in the frame-save cycle counts as a delivery fault. During a first-level delivery it causes vector 8 to be delivered with `hnd_err = 0` and `hnd_err_vld = 1`.
- R4: A delivery fault while vector 8 is being delivered enters shutdown. No `hnd_valid` is produced for it, and none is produced while halted.
- R5: When a request for vector 14 is accepted, `exc_lin_addr` is loaded into `fault_addr`. A request for any other vector leaves `fault_addr` unchanged.
- R6: A successful delivery clears the nesting level. A later, unrelated fault therefore starts again at level one and escalates at most to a double fault.
- R7: Each entry into shutdown raises `shut_cycle` for exactly one clock, and `halted` stays high. While halted, `exc_req` is ignored.
- R8: While reset is low, and up to the first rising edge after its release, the controller is idle, not halted, and shows `restart_fetch` high with `restart_addr = 0xFFFFFFF0`.
- R9: A high `nmi` sampled while halted leaves shutdown. Vector 2 is then delivered through the normal path with the same latency as R1. `nmi` has no effect when the controller is not halted.
- R10: With `idt_limit = 0`, `shut_cycle` is high in the cycle after the third rising edge, counting the edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the processor RESET |
| exc_req | input | 1 | Exception request, accepted only when idle |
| exc_vec | input | 8 | Requested vector |
| exc_err_vld | input | 1 | Request carries an error code |
| exc_err | input | 16 | Request error code |
| exc_lin_addr | input | 32 | Faulting linear address for vector 14 |
| idt_base | input | 32 | Descriptor table base address |
| idt_limit | input | 16 | Descriptor table limit in bytes, inclusive |
| desc_req | output | 1 | Gate fetch request |
| desc_addr | output | 32 | Gate fetch address |
| desc_ack | input | 1 | Gate fetch completed |
| desc_present | input | 1 | Fetched gate is present, valid with desc_ack |
| push_fault | input | 1 | Frame save failed, sampled in the frame-save cycle |
| nmi | input | 1 | Non-maskable interrupt, acts only while halted |
| hnd_valid | output | 1 | One-cycle handler dispatch strobe |
| hnd_vec | output | 8 | Dispatched handler vector |
| hnd_err_vld | output | 1 | An error code is to be pushed |
| hnd_err | output | 16 | Error code to push |
| fault_addr | output | 32 | Latched page-fault linear address |
| shut_cycle | output | 1 | Shutdown bus-cycle strobe |
| halted | output | 1 | Processor is in shutdown |
| busy | output | 1 | A delivery is in progress |
| restart_fetch | output | 1 | Fetch restarts from restart_addr |
| restart_addr | output | 32 | Reset fetch address |

## Verification
A clean delivery produces its dispatch strobe in the cycle after the fourth rising edge, counting the accepting edge. Each escalation adds three edges, so a double fault after a missing gate appears after the sixth edge. A limit overflow skips the fetch and appears one edge sooner. Shutdown after two frame-save failures appears after the seventh edge, and a zero limit reaches shutdown after the third. The bench drives every input just after a falling edge and counts falling edges from the accepting one. It samples exactly in the cycle each result is due, and checks the cycle before and after where the one-cycle width of a strobe matters. Counters of dispatch strobes and shutdown strobes show that halted stimulus produces neither.

// File: rtl/exc_escalate_pkg.sv
package exc_escalate_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_FETCH,
      ST_PUSH,
      ST_SHUT
   } dlv_state_t;

   localparam int unsigned DF_VECTOR  = 8;
   localparam int unsigned NMI_VECTOR = 2;
   localparam int unsigned PF_VECTOR  = 14;
   localparam int unsigned LVL_FIRST  = 1;
   localparam int unsigned LVL_DOUBLE = 2;

endpackage

// File: rtl/exc_idt_probe.sv
module exc_idt_probe #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LIMIT_W    = 16,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned ENTRY_LOG2 = 3
) (
   input  logic [VEC_W-1:0]   vec,
   input  logic [ADDR_W-1:0]  base,
   input  logic [LIMIT_W-1:0] limit,
   output logic [ADDR_W-1:0]  entry_addr,
   output logic               in_range
);
   localparam int unsigned OFF_W = VEC_W + ENTRY_LOG2;
   localparam int unsigned CMP_W = ((OFF_W > LIMIT_W) ? OFF_W : LIMIT_W) + 1;
   localparam int unsigned LAST_BYTE = (1 << ENTRY_LOG2) - 1;

   if (ADDR_W < OFF_W) begin : g_bad_addr_w
      $error("exc_idt_probe: ADDR_W too narrow for the table offset");
   end

   logic [OFF_W-1:0] offset;
   logic [CMP_W-1:0] last_byte;

   always_comb begin
      offset     = {vec, {ENTRY_LOG2{1'b0}}};
      last_byte  = CMP_W'(offset) + CMP_W'(LAST_BYTE);
      in_range   = (last_byte <= CMP_W'(limit));
      entry_addr = base + ADDR_W'(offset);
   end
endmodule

// File: rtl/exc_nest_fsm.sv
module exc_nest_fsm
   import exc_escalate_pkg::*;
#(
   parameter int unsigned VEC_W = 8,
   parameter int unsigned ERR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             exc_req,
   input  logic [VEC_W-1:0] exc_vec,
   input  logic             exc_err_vld,
   input  logic [ERR_W-1:0] exc_err,
   input  logic             nmi,
   input  logic             in_range,
   input  logic             desc_ack,
   input  logic             desc_present,
   input  logic             push_fault,
   output logic [VEC_W-1:0] cur_vec,
   output logic             desc_req,
   output logic             hnd_valid,
   output logic [VEC_W-1:0] hnd_vec,
   output logic             hnd_err_vld,
   output logic [ERR_W-1:0] hnd_err,
   output logic             halted,
   output logic             busy,
   output logic             pf_accept
);
   localparam int unsigned NEST_W = 2;
   localparam logic [VEC_W-1:0]  DF_V  = VEC_W'(DF_VECTOR);
   localparam logic [VEC_W-1:0]  NMI_V = VEC_W'(NMI_VECTOR);
   localparam logic [VEC_W-1:0]  PF_V  = VEC_W'(PF_VECTOR);
   localparam logic [NEST_W-1:0] L1    = NEST_W'(LVL_FIRST);
   localparam logic [NEST_W-1:0] L2    = NEST_W'(LVL_DOUBLE);

   dlv_state_t        state;
   logic [NEST_W-1:0] nest;
   logic [ERR_W-1:0]  cur_err;
   logic              cur_err_vld;
   logic              dlv_fault;
   logic              accept;

   always_comb begin
      accept    = (state == ST_IDLE) && exc_req;
      pf_accept = accept && (exc_vec == PF_V);
      dlv_fault = ((state == ST_LOOKUP) && !in_range) ||
                  ((state == ST_FETCH) && desc_ack && !desc_present) ||
                  ((state == ST_PUSH) && push_fault);
      desc_req  = (state == ST_FETCH);
      halted    = (state == ST_SHUT);
      busy      = (state == ST_LOOKUP) || (state == ST_FETCH) || (state == ST_PUSH);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         nest        <= '0;
         cur_vec     <= '0;
         cur_err     <= '0;
         cur_err_vld <= 1'b0;
         hnd_valid   <= 1'b0;
         hnd_vec     <= '0;
         hnd_err     <= '0;
         hnd_err_vld <= 1'b0;
      end else begin
         hnd_valid <= 1'b0;
         if (dlv_fault) begin
            if (nest < L2) begin
               cur_vec     <= DF_V;
               cur_err     <= '0;
               cur_err_vld <= 1'b1;
               nest        <= L2;
               state       <= ST_LOOKUP;
            end else begin
               nest  <= '0;
               state <= ST_SHUT;
            end
         end else begin
            case (state)
               ST_IDLE: if (exc_req) begin
                  cur_vec     <= exc_vec;
                  cur_err     <= exc_err_vld ? exc_err : '0;
                  cur_err_vld <= exc_err_vld;
                  nest        <= L1;
                  state       <= ST_LOOKUP;
               end
               ST_LOOKUP: state <= ST_FETCH;
               ST_FETCH:  if (desc_ack) state <= ST_PUSH;
               ST_PUSH: begin
                  hnd_valid   <= 1'b1;
                  hnd_vec     <= cur_vec;
                  hnd_err     <= cur_err;
                  hnd_err_vld <= cur_err_vld;
                  nest        <= '0;
                  state       <= ST_IDLE;
               end
               ST_SHUT: if (nmi) begin
                  cur_vec     <= NMI_V;
                  cur_err     <= '0;
                  cur_err_vld <= 1'b0;
                  nest        <= L1;
                  state       <= ST_LOOKUP;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/exc_shut_pulse.sv
module exc_shut_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic pulse
);
   logic level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   assign pulse = level && !level_q;
endmodule

// File: rtl/exc_fault_addr_reg.sv
module exc_fault_addr_reg #(
   parameter int unsigned ADDR_W = 32,
   parameter bit          KEEP   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);
   if (KEEP) begin : g_keep
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    q <= '0;
         else if (load) q <= d;
      end
   end else begin : g_none
      assign q = '0;
   end
endmodule

// File: rtl/exc_escalate_ctrl.sv
module exc_escalate_ctrl #(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned LIMIT_W      = 16,
   parameter int unsigned VEC_W        = 8,
   parameter int unsigned ERR_W        = 16,
   parameter int unsigned ENTRY_LOG2   = 3,
   parameter bit          KEEP_PF_ADDR = 1'b1,
   parameter logic [ADDR_W-1:0] RESET_VECTOR = ADDR_W'(32'hFFFF_FFF0)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exc_req,
   input  logic [VEC_W-1:0]   exc_vec,
   input  logic               exc_err_vld,
   input  logic [ERR_W-1:0]   exc_err,
   input  logic [ADDR_W-1:0]  exc_lin_addr,
   input  logic [ADDR_W-1:0]  idt_base,
   input  logic [LIMIT_W-1:0] idt_limit,
   output logic               desc_req,
   output logic [ADDR_W-1:0]  desc_addr,
   input  logic               desc_ack,
   input  logic               desc_present,
   input  logic               push_fault,
   input  logic               nmi,
   output logic               hnd_valid,
   output logic [VEC_W-1:0]   hnd_vec,
   output logic               hnd_err_vld,
   output logic [ERR_W-1:0]   hnd_err,
   output logic [ADDR_W-1:0]  fault_addr,
   output logic               shut_cycle,
   output logic               halted,
   output logic               busy,
   output logic               restart_fetch,
   output logic [ADDR_W-1:0]  restart_addr
);
   if (VEC_W < 4) begin : g_bad_vec_w
      $error("exc_escalate_ctrl: VEC_W must hold vector 14");
   end
   if (ERR_W < 1) begin : g_bad_err_w
      $error("exc_escalate_ctrl: ERR_W must be positive");
   end

   logic [VEC_W-1:0] cur_vec;
   logic             in_range;
   logic             pf_accept;
   logic             started;

   exc_idt_probe #(
      .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .VEC_W(VEC_W), .ENTRY_LOG2(ENTRY_LOG2)
   ) u_probe (
      .vec(cur_vec), .base(idt_base), .limit(idt_limit),
      .entry_addr(desc_addr), .in_range(in_range)
   );

   exc_nest_fsm #(.VEC_W(VEC_W), .ERR_W(ERR_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .exc_req(exc_req), .exc_vec(exc_vec), .exc_err_vld(exc_err_vld), .exc_err(exc_err),
      .nmi(nmi), .in_range(in_range), .desc_ack(desc_ack), .desc_present(desc_present),
      .push_fault(push_fault), .cur_vec(cur_vec), .desc_req(desc_req),
      .hnd_valid(hnd_valid), .hnd_vec(hnd_vec), .hnd_err_vld(hnd_err_vld), .hnd_err(hnd_err),
      .halted(halted), .busy(busy), .pf_accept(pf_accept)
   );

   exc_shut_pulse u_pulse (
      .clk(clk), .rst_n(rst_n), .level(halted), .pulse(shut_cycle)
   );

   exc_fault_addr_reg #(.ADDR_W(ADDR_W), .KEEP(KEEP_PF_ADDR)) u_cr (
      .clk(clk), .rst_n(rst_n), .load(pf_accept), .d(exc_lin_addr), .q(fault_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
   end

   assign restart_fetch = !started;
   assign restart_addr  = RESET_VECTOR;
endmodule

// File: rtl/exc_escalate_chk.sv
module exc_escalate_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned VEC_W  = 8,
   parameter int unsigned ERR_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exc_req,
   input logic              nmi,
   input logic              hnd_valid,
   input logic [VEC_W-1:0]  hnd_vec,
   input logic              hnd_err_vld,
   input logic [ERR_W-1:0]  hnd_err,
   input logic              shut_cycle,
   input logic              halted,
   input logic [ADDR_W-1:0] fault_addr
);
   a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      shut_cycle |=> !shut_cycle);

   a_r7_strobe_halts: assert property (@(posedge clk) disable iff (!rst_n)
      shut_cycle |-> halted);

   a_r7_stay_halted: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !nmi) |=> halted);

   a_r4_no_dispatch_halted: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !hnd_valid);

   a_r3_df_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
      (hnd_valid && hnd_vec == VEC_W'(8)) |-> (hnd_err_vld && hnd_err == '0));

   a_r1_single_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
      hnd_valid |=> !hnd_valid);

   a_r5_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_req |=> $stable(fault_addr));
endmodule

bind exc_escalate_ctrl exc_escalate_chk #(
   .ADDR_W(ADDR_W), .VEC_W(VEC_W), .ERR_W(ERR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .nmi(nmi),
   .hnd_valid(hnd_valid), .hnd_vec(hnd_vec), .hnd_err_vld(hnd_err_vld), .hnd_err(hnd_err),
   .shut_cycle(shut_cycle), .halted(halted), .fault_addr(fault_addr)
);

// File: tb/exc_escalate_ctrl_bench.sv
module exc_escalate_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_req = 1'b0;
   logic [7:0]  exc_vec = '0;
   logic        exc_err_vld = 1'b0;
   logic [15:0] exc_err = '0;
   logic [31:0] exc_lin_addr = '0;
   logic [31:0] idt_base = 32'h0000_1000;
   logic [15:0] idt_limit = 16'h07FF;
   logic        desc_req;
   logic [31:0] desc_addr;
   logic        desc_ack = 1'b1;
   logic        desc_present;
   logic        push_fault = 1'b0;
   logic        nmi = 1'b0;
   logic        hnd_valid;
   logic [7:0]  hnd_vec;
   logic        hnd_err_vld;
   logic [15:0] hnd_err;
   logic [31:0] fault_addr;
   logic        shut_cycle;
   logic        halted;
   logic        busy;
   logic        restart_fetch;
   logic [31:0] restart_addr;

   logic        bad_en = 1'b0;
   logic [31:0] bad_addr = '0;
   int checks = 0;
   int fails = 0;
   int hnd_cnt = 0;
   int shut_cnt = 0;

   always #5 clk = ~clk;

   // missing-gate model of the external table
   assign desc_present = !(bad_en && desc_addr == bad_addr);

   always @(negedge clk) begin
      if (hnd_valid)  hnd_cnt++;
      if (shut_cycle) shut_cnt++;
   end

   exc_escalate_ctrl u_exc_escalate_ctrl (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_vec(exc_vec),
      .exc_err_vld(exc_err_vld), .exc_err(exc_err), .exc_lin_addr(exc_lin_addr),
      .idt_base(idt_base), .idt_limit(idt_limit), .desc_req(desc_req), .desc_addr(desc_addr),
      .desc_ack(desc_ack), .desc_present(desc_present), .push_fault(push_fault), .nmi(nmi),
      .hnd_valid(hnd_valid), .hnd_vec(hnd_vec), .hnd_err_vld(hnd_err_vld), .hnd_err(hnd_err),
      .fault_addr(fault_addr), .shut_cycle(shut_cycle), .halted(halted), .busy(busy),
      .restart_fetch(restart_fetch), .restart_addr(restart_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // returns at the falling edge after the accepting rising edge
   task automatic pulse_req(input logic [7:0] v, input logic ev, input logic [15:0] e,
                            input logic [31:0] la);
      exc_vec = v; exc_err_vld = ev; exc_err = e; exc_lin_addr = la; exc_req = 1'b1;
      @(negedge clk);
      exc_req = 1'b0;
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R8 restart_fetch after release", 32'(restart_fetch), 32'd1);
      chk("R8 restart_addr", restart_addr, 32'hFFFF_FFF0);
      chk("R8 halted", 32'(halted), 32'd0);
      chk("R8 busy", 32'(busy), 32'd0);
      chk("R8 hnd_valid", 32'(hnd_valid), 32'd0);
      chk("R8 shut_cycle", 32'(shut_cycle), 32'd0);
      @(negedge clk);
      chk("R8 restart_fetch drops", 32'(restart_fetch), 32'd0);
   endtask

   task automatic t_normal;
      pulse_req(8'd32, 1'b0, 16'h0, 32'h0);
      wait_n(1);
      chk("R2 desc_req in fetch", 32'(desc_req), 32'd1);
      chk("R2 desc_addr", desc_addr, 32'h0000_1100);
      wait_n(1);
      chk("R1 no early dispatch", 32'(hnd_valid), 32'd0);
      wait_n(1);
      chk("R1 hnd_valid", 32'(hnd_valid), 32'd1);
      chk("R1 hnd_vec", 32'(hnd_vec), 32'd32);
      chk("R1 hnd_err_vld", 32'(hnd_err_vld), 32'd0);
      wait_n(1);
      chk("R1 one-cycle strobe", 32'(hnd_valid), 32'd0);
      pulse_req(8'd13, 1'b1, 16'h1234, 32'h0);
      wait_n(3);
      chk("R1 vec with code", 32'(hnd_vec), 32'd13);
      chk("R1 err code", 32'(hnd_err), 32'h1234);
      chk("R1 err valid", 32'(hnd_err_vld), 32'd1);
      wait_n(1);
   endtask

   task automatic t_page_fault;
      pulse_req(8'd14, 1'b1, 16'h0002, 32'hDEAD_B000);
      chk("R5 address latched", fault_addr, 32'hDEAD_B000);
      wait_n(3);
      chk("R5 vector 14 delivered", 32'(hnd_vec), 32'd14);
      wait_n(1);
      pulse_req(8'd32, 1'b0, 16'h0, 32'h1234_5678);
      wait_n(3);
      chk("R5 other vector keeps address", fault_addr, 32'hDEAD_B000);
      wait_n(1);
   endtask

   task automatic t_not_present;
      bad_en = 1'b1; bad_addr = 32'h0000_1000 + 32'd40 * 8;
      pulse_req(8'd40, 1'b1, 16'h0055, 32'h0);
      wait_n(4);
      chk("R3 no dispatch before DF", 32'(hnd_valid), 32'd0);
      wait_n(1);
      chk("R3 DF strobe", 32'(hnd_valid), 32'd1);
      chk("R3 DF vector", 32'(hnd_vec), 32'd8);
      chk("R3 DF code zero", 32'(hnd_err), 32'd0);
      chk("R3 DF code valid", 32'(hnd_err_vld), 32'd1);
      wait_n(1);
      // R6: second unrelated fault escalates only to a double fault again
      pulse_req(8'd40, 1'b0, 16'h0, 32'h0);
      wait_n(5);
      chk("R6 DF again after clear", 32'(hnd_vec), 32'd8);
      chk("R6 DF strobe again", 32'(hnd_valid), 32'd1);
      chk("R6 not halted", 32'(halted), 32'd0);
      bad_en = 1'b0;
      wait_n(1);
   endtask

   task automatic t_limit;
      idt_limit = 16'd87;
      pulse_req(8'd10, 1'b0, 16'h0, 32'h0);
      wait_n(3);
      chk("R2 last gate in range", 32'(hnd_vec), 32'd10);
      wait_n(1);
      pulse_req(8'd11, 1'b0, 16'h0, 32'h0);
      wait_n(3);
      chk("R2 no early DF", 32'(hnd_valid), 32'd0);
      wait_n(1);
      chk("R2 beyond limit gives DF", 32'(hnd_vec), 32'd8);
      chk("R3 limit DF strobe", 32'(hnd_valid), 32'd1);
      idt_limit = 16'h07FF;
      wait_n(1);
   endtask

   task automatic t_push_shutdown;
      int h0;
      int s0;
      h0 = hnd_cnt; s0 = shut_cnt;
      push_fault = 1'b1;
      pulse_req(8'd32, 1'b0, 16'h0, 32'h0);
      wait_n(5);
      chk("R4 not yet halted", 32'(halted), 32'd0);
      wait_n(1);
      chk("R7 strobe on entry", 32'(shut_cycle), 32'd1);
      chk("R4 halted", 32'(halted), 32'd1);
      wait_n(1);
      chk("R7 strobe one clock", 32'(shut_cycle), 32'd0);
      chk("R4 no dispatch", 32'(hnd_cnt - h0), 32'd0);
      push_fault = 1'b0;
      // R7: requests ignored while halted
      pulse_req(8'd32, 1'b0, 16'h0, 32'h0);
      wait_n(5);
      chk("R7 still halted", 32'(halted), 32'd1);
      chk("R7 request ignored", 32'(hnd_cnt - h0), 32'd0);
      chk("R7 single strobe", 32'(shut_cnt - s0), 32'd1);
      // R9: NMI leaves shutdown and delivers vector 2
      nmi = 1'b1;
      @(negedge clk);
      nmi = 1'b0;
      chk("R9 left shutdown", 32'(halted), 32'd0);
      wait_n(3);
      chk("R9 NMI dispatch", 32'(hnd_valid), 32'd1);
      chk("R9 NMI vector", 32'(hnd_vec), 32'd2);
      wait_n(1);
      h0 = hnd_cnt;
      nmi = 1'b1;
      @(negedge clk);
      nmi = 1'b0;
      wait_n(5);
      chk("R9 NMI ignored when running", 32'(hnd_cnt - h0), 32'd0);
      chk("R9 stays idle", 32'(busy), 32'd0);
   endtask

   task automatic t_zero_limit;
      int s0;
      s0 = shut_cnt;
      idt_limit = 16'd0;
      pulse_req(8'd0, 1'b0, 16'h0, 32'h0);
      wait_n(1);
      chk("R10 no strobe after second edge", 32'(shut_cycle), 32'd0);
      wait_n(1);
      chk("R10 strobe after third edge", 32'(shut_cycle), 32'd1);
      chk("R10 halted", 32'(halted), 32'd1);
      wait_n(2);
      chk("R7 one strobe per entry", 32'(shut_cnt - s0), 32'd1);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R8 reset leaves shutdown", 32'(halted), 32'd0);
      chk("R8 restart_fetch in reset", 32'(restart_fetch), 32'd1);
      idt_limit = 16'h07FF;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 restart_fetch after first edge", 32'(restart_fetch), 32'd0);
   endtask

   initial begin
      t_reset();
      t_normal();
      t_page_fault();
      t_not_present();
      t_limit();
      t_push_shutdown();
      t_zero_limit();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule